// File: doc/BRIEF.md
# Single-Channel PWM with Filtered Emergency Shutdown

This block produces one left-aligned pulse-width modulated output. A counter advances on an external tick, which is a clock enable derived from the bus clock. The counter runs through a programmable period. A polarity bit decides whether the output starts each period high or low, and the output changes level when the counter reaches the duty count. Software writes the period and the duty into buffer registers. The running waveform only takes the new values at a period boundary, so a reconfiguration never produces a truncated or malformed pulse.

An emergency input, qualified by a short digital filter, overrides the waveform. When it trips, the output goes at once to a programmed safe level and a sticky flag is raised. The flag can request an interrupt. Software clears the flag and asks for a restart. The restart takes effect at the next period start, and only if the emergency input is no longer asserted at that moment. All configuration goes through a small four-word register port with combinational read data.

Top module: `pwm_sd_chan`

## Requirements
- R1: After reset, every register word reads zero while the emergency input is held low, and `pwm_out` and `irq` are low.
- R2: The counter advances once per cycle with `tick` high, counts 0 to P-1 for an active period P, and then wraps to 0. With polarity 1 (word 0 bit 1), the enabled output (word 0 bit 0) is high while the counter is below the active duty D and low otherwise.
- R3: With polarity 0, the enabled output is low while the counter is below D and high otherwise, so D sets the low time.
- R4: D = 0 gives a constant output (low for polarity 1, high for polarity 0). D ≥ P gives the opposite constant. P = 0 holds the counter at 0.
- R5: The period (word 1) and duty (word 2) read back the last written value. The active copies load from these buffers when the counter wraps, and on every cycle while the channel is disabled.
- R6: While disabled, the counter is held at 0 and `pwm_out` is low unless shutdown forces it.
- R7: With shutdown enabled (word 3 bit 0), the input counts as tripped only after it has been sampled at the active level (word 3 bit 1) on two consecutive clock edges. A single-cycle pulse changes neither the output nor the flag.
- R8: From the edge that completes the filter onward, `pwm_out` equals the forced level (word 3 bit 4) whether or not the channel is enabled, and the flag (word 3 bit 7) becomes 1 one edge later.
- R9: `irq` is high exactly while the flag and the interrupt enable (word 3 bit 6) are both 1. Writing 1 to bit 7 clears the flag, unless the input is still tripped.
- R10: Writing 1 to word 3 bit 5 arms a restart. The forced state ends at the first period start (a counter wrap, or any cycle while disabled) at which the latest sample of the input is inactive. Until then the restart stays armed.
- R11: Word 3 reads {flag, ie, 0, forced level, 0, latest input sample, active level, shutdown enable} from bit 7 down to bit 0. The restart bit and bit 3 always read 0.
- R12: Clearing the shutdown enable ends the forced state at the next edge, with no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| sd_pin | input | 1 | Emergency shutdown input |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 control, 1 period, 2 duty, 3 shutdown |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Shutdown interrupt request |

## Verification
A wrong counter or a wrong active-register value shows as an edge of `pwm_out` placed in the wrong cycle, and this appears within one period of the fault. A premature buffer load moves that edge before the wrap, so the output is compared against an independent model on every cycle rather than sampled once per period. A faulty filter or forced state shows on `pwm_out` one edge after the second active sample. A faulty flag or restart arm shows on `irq`, or on the word 3 readback, one edge later. A faulty release shows as the output returning in the wrong period.

// File: rtl/pwm_sd_pkg.sv
package pwm_sd_pkg;

  // register word selects
  localparam logic [1:0] RA_CTRL   = 2'd0;
  localparam logic [1:0] RA_PERIOD = 2'd1;
  localparam logic [1:0] RA_DUTY   = 2'd2;
  localparam logic [1:0] RA_SHUT   = 2'd3;

  // control word bits
  localparam int CB_EN  = 0;
  localparam int CB_POL = 1;

  // shutdown word bits (software decodes these positions)
  localparam int SB_FLAG    = 7;
  localparam int SB_IE      = 6;
  localparam int SB_RESTART = 5;
  localparam int SB_FORCE   = 4;
  localparam int SB_PIN     = 2;
  localparam int SB_LVL     = 1;
  localparam int SB_EN      = 0;

  typedef struct packed {
    logic ie;
    logic force_lvl;
    logic act_lvl;
    logic sd_en;
  } sd_cfg_t;

endpackage

// File: rtl/pwm_sd_regs.sv
module pwm_sd_regs
  import pwm_sd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  input  logic              pin_now,
  output logic [DATA_W-1:0] rdata,
  output logic              ch_en,
  output logic              pol,
  output logic [CNT_W-1:0]  per_buf,
  output logic [CNT_W-1:0]  duty_buf,
  output sd_cfg_t           sd_cfg,
  output logic              restart_req,
  output logic              flag_clr
);

  logic             en_q, en_n;
  logic             pol_q, pol_n;
  logic [CNT_W-1:0] per_q, per_n;
  logic [CNT_W-1:0] duty_q, duty_n;
  sd_cfg_t          cfg_q, cfg_n;

  logic wr_ctrl, wr_per, wr_duty, wr_shut;

  assign wr_ctrl = we && (addr == RA_CTRL);
  assign wr_per  = we && (addr == RA_PERIOD);
  assign wr_duty = we && (addr == RA_DUTY);
  assign wr_shut = we && (addr == RA_SHUT);

  // next-state
  always_comb begin
    en_n   = en_q;
    pol_n  = pol_q;
    per_n  = per_q;
    duty_n = duty_q;
    cfg_n  = cfg_q;
    if (wr_ctrl) begin
      en_n  = wdata[CB_EN];
      pol_n = wdata[CB_POL];
    end
    if (wr_per) begin
      per_n = wdata[CNT_W-1:0];
    end
    if (wr_duty) begin
      duty_n = wdata[CNT_W-1:0];
    end
    if (wr_shut) begin
      cfg_n.ie        = wdata[SB_IE];
      cfg_n.force_lvl = wdata[SB_FORCE];
      cfg_n.act_lvl   = wdata[SB_LVL];
      cfg_n.sd_en     = wdata[SB_EN];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
      cfg_q  <= '0;
    end else begin
      en_q   <= en_n;
      pol_q  <= pol_n;
      per_q  <= per_n;
      duty_q <= duty_n;
      cfg_q  <= cfg_n;
    end
  end

  // one-cycle command strobes
  assign restart_req = wr_shut && wdata[SB_RESTART];
  assign flag_clr    = wr_shut && wdata[SB_FLAG];

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: begin
        rdata[CB_EN]  = en_q;
        rdata[CB_POL] = pol_q;
      end
      RA_PERIOD: rdata[CNT_W-1:0] = per_q;
      RA_DUTY:   rdata[CNT_W-1:0] = duty_q;
      default: begin
        rdata[SB_FLAG]  = flag;
        rdata[SB_IE]    = cfg_q.ie;
        rdata[SB_FORCE] = cfg_q.force_lvl;
        rdata[SB_PIN]   = pin_now;
        rdata[SB_LVL]   = cfg_q.act_lvl;
        rdata[SB_EN]    = cfg_q.sd_en;
      end
    endcase
  end

  assign ch_en    = en_q;
  assign pol      = pol_q;
  assign per_buf  = per_q;
  assign duty_buf = duty_q;
  assign sd_cfg   = cfg_q;

endmodule

// File: rtl/pwm_sd_counter.sv
module pwm_sd_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_en,
  input  logic             pol,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_buf,
  input  logic [CNT_W-1:0] duty_buf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_act,
  output logic             per_end,
  output logic             per_start,
  output logic             wave
);

  localparam int CW1 = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] per_q, per_n;
  logic [CNT_W-1:0] duty_q, duty_n;
  logic [CW1-1:0]   cnt_inc;
  logic             at_last;
  logic             below_duty;

  assign cnt_inc   = {1'b0, cnt_q} + CW1'(1);
  assign at_last   = cnt_inc >= {1'b0, per_q};
  assign per_end   = ch_en && tick && at_last;
  assign per_start = per_end || !ch_en;

  // next-state
  always_comb begin
    cnt_n  = cnt_q;
    per_n  = per_q;
    duty_n = duty_q;
    if (!ch_en) begin
      cnt_n  = '0;
      per_n  = per_buf;
      duty_n = duty_buf;
    end else if (tick) begin
      if (at_last) begin
        cnt_n  = '0;
        per_n  = per_buf;
        duty_n = duty_buf;
      end else begin
        cnt_n = cnt_inc[CNT_W-1:0];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      per_q  <= per_n;
      duty_q <= duty_n;
    end
  end

  assign below_duty = cnt_q < duty_q;
  assign wave       = ch_en && (pol ? below_duty : !below_duty);
  assign cnt        = cnt_q;
  assign per_act    = per_q;

endmodule

// File: rtl/pwm_sd_guard.sv
module pwm_sd_guard
  import pwm_sd_pkg::*;
#(
  parameter int FILT_LEN = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sd_pin,
  input  sd_cfg_t cfg,
  input  logic    restart_req,
  input  logic    flag_clr,
  input  logic    per_start,
  output logic    det,
  output logic    shut,
  output logic    flag,
  output logic    pin_now
);

  logic [FILT_LEN-1:0] hist_q, hist_n;
  logic                shut_q, shut_n;
  logic                pend_q, pend_n;
  logic                flag_q, flag_n;
  logic [FILT_LEN-1:0] at_lvl;
  logic                release_ok;

  // per-sample level compare
  for (genvar gi = 0; gi < FILT_LEN; gi++) begin : g_cmp
    assign at_lvl[gi] = (hist_q[gi] == cfg.act_lvl);
  end

  assign det        = cfg.sd_en && (&at_lvl);
  assign release_ok = pend_q && per_start && !at_lvl[0];

  // next-state
  always_comb begin
    hist_n = {hist_q[FILT_LEN-2:0], sd_pin};

    shut_n = shut_q;
    if (!cfg.sd_en) begin
      shut_n = 1'b0;
    end else if (det) begin
      shut_n = 1'b1;
    end else if (release_ok) begin
      shut_n = 1'b0;
    end

    pend_n = pend_q;
    if (restart_req) begin
      pend_n = 1'b1;
    end else if (release_ok) begin
      pend_n = 1'b0;
    end

    flag_n = flag_q;
    if (det) begin
      flag_n = 1'b1;
    end else if (flag_clr) begin
      flag_n = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      shut_q <= 1'b0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hist_q <= hist_n;
      shut_q <= shut_n;
      pend_q <= pend_n;
      flag_q <= flag_n;
    end
  end

  assign shut    = shut_q;
  assign flag    = flag_q;
  assign pin_now = hist_q[0];

endmodule

// File: rtl/pwm_sd_chan.sv
module pwm_sd_chan
  import pwm_sd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int FILT_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sd_pin,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out,
  output logic              irq
);

  logic             ch_en;
  logic             pol;
  logic [CNT_W-1:0] per_buf;
  logic [CNT_W-1:0] duty_buf;
  sd_cfg_t          sd_cfg;
  logic             restart_req;
  logic             flag_clr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_act;
  logic             per_end;
  logic             per_start;
  logic             wave;
  logic             sd_det;
  logic             shut_q;
  logic             flag_q;
  logic             pin_now;
  logic             sd_force;
  logic             sd_en;
  logic             sd_ie;

  pwm_sd_regs #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .flag       (flag_q),
    .pin_now    (pin_now),
    .rdata      (reg_rdata),
    .ch_en      (ch_en),
    .pol        (pol),
    .per_buf    (per_buf),
    .duty_buf   (duty_buf),
    .sd_cfg     (sd_cfg),
    .restart_req(restart_req),
    .flag_clr   (flag_clr)
  );

  pwm_sd_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_en    (ch_en),
    .pol      (pol),
    .tick     (tick),
    .per_buf  (per_buf),
    .duty_buf (duty_buf),
    .cnt      (cnt_q),
    .per_act  (per_act),
    .per_end  (per_end),
    .per_start(per_start),
    .wave     (wave)
  );

  pwm_sd_guard #(
    .FILT_LEN(FILT_LEN)
  ) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd_pin     (sd_pin),
    .cfg        (sd_cfg),
    .restart_req(restart_req),
    .flag_clr   (flag_clr),
    .per_start  (per_start),
    .det        (sd_det),
    .shut       (shut_q),
    .flag       (flag_q),
    .pin_now    (pin_now)
  );

  assign sd_force = sd_cfg.force_lvl;
  assign sd_en    = sd_cfg.sd_en;
  assign sd_ie    = sd_cfg.ie;

  // forced level overrides the waveform from the filter edge onward
  assign pwm_out = (shut_q || sd_det) ? sd_force : wave;
  assign irq     = flag_q && sd_ie;

endmodule

// File: rtl/pwm_sd_chan_chk.sv
module pwm_sd_chan_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_out,
  input logic             irq,
  input logic             shut,
  input logic             det,
  input logic             flag,
  input logic             force_lvl,
  input logic             sd_en,
  input logic             ch_en,
  input logic             per_end,
  input logic             per_start,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_act
);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && per_act != '0) |-> (cnt < per_act)); // R2

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !per_end) |=> (per_act == $past(per_act))); // R5

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en && !shut && !det) |-> !pwm_out); // R6

  AST_TRIP_NEEDS_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (shut && !$past(shut)) |-> $past(det)); // R7

  AST_FORCED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    shut |-> (pwm_out == force_lvl)); // R8

  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !$past(flag)) |-> $past(det)); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R9

  AST_RELEASE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut && $past(shut)) |-> ($past(per_start) || !$past(sd_en))); // R10

endmodule

bind pwm_sd_chan pwm_sd_chan_chk #(
  .CNT_W(CNT_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_out  (pwm_out),
  .irq      (irq),
  .shut     (shut_q),
  .det      (sd_det),
  .flag     (flag_q),
  .force_lvl(sd_force),
  .sd_en    (sd_en),
  .ch_en    (ch_en),
  .per_end  (per_end),
  .per_start(per_start),
  .cnt      (cnt_q),
  .per_act  (per_act)
);

// File: tb/test_pwm_sd_chan.sv
module test_pwm_sd_chan;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       sd_pin;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       pwm_out;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  int    tick_div = 1;
  int    tick_ph = 0;
  bit    done = 0;
  string cur_req = "R1";

  pwm_sd_chan i_pwm_sd_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .sd_pin   (sd_pin),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pwm_out  (pwm_out),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // tick pattern driven away from the active edge
  always @(negedge clk) begin
    if (tick_div <= 1) begin
      tick    <= 1'b1;
      tick_ph <= 0;
    end else begin
      tick    <= (tick_ph == 0);
      tick_ph <= (tick_ph + 1) % tick_div;
    end
  end

  // ---------------- behavioural reference model ----------------
  bit m_en, m_pol, m_ie, m_force, m_lvl, m_sden;
  int m_pbuf, m_dbuf, m_pact, m_dact, m_cnt;
  bit m_shut, m_pend, m_flag;
  bit m_hist[$];
  bit m_det, m_wrap, m_ps, m_rel, m_wr3;

  function automatic bit model_det();
    return m_sden && (m_hist[0] == m_lvl) && (m_hist[1] == m_lvl);
  endfunction

  function automatic bit model_out();
    if (m_shut || model_det()) return m_force;
    if (!m_en) return 1'b0;
    return m_pol ? (m_cnt < m_dact) : !(m_cnt < m_dact);
  endfunction

  function automatic logic [7:0] model_read(input int a);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      0: v = {6'b0, m_pol, m_en};
      1: v = 8'(m_pbuf);
      2: v = 8'(m_dbuf);
      default: v = {m_flag, m_ie, 1'b0, m_force, 1'b0, m_hist[0], m_lvl, m_sden};
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_ie = 0; m_force = 0; m_lvl = 0; m_sden = 0;
      m_pbuf = 0; m_dbuf = 0; m_pact = 0; m_dact = 0; m_cnt = 0;
      m_shut = 0; m_pend = 0; m_flag = 0;
      m_hist = '{1'b0, 1'b0};
    end else begin
      m_det  = model_det();
      m_wrap = tick && (m_cnt + 1 >= m_pact);
      m_ps   = !m_en || m_wrap;
      m_rel  = m_pend && m_ps && (m_hist[0] != m_lvl);
      m_wr3  = reg_we && (reg_addr == 2'd3);
      if (!m_sden)     m_shut = 0;
      else if (m_det)  m_shut = 1;
      else if (m_rel)  m_shut = 0;
      if (m_wr3 && reg_wdata[5]) m_pend = 1;
      else if (m_rel)            m_pend = 0;
      if (m_det)                      m_flag = 1;
      else if (m_wr3 && reg_wdata[7]) m_flag = 0;
      if (!m_en) begin
        m_cnt = 0; m_pact = m_pbuf; m_dact = m_dbuf;
      end else if (tick) begin
        if (m_wrap) begin
          m_cnt = 0; m_pact = m_pbuf; m_dact = m_dbuf;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      m_hist.push_front(sd_pin);
      void'(m_hist.pop_back());
      if (reg_we) begin
        case (reg_addr)
          2'd0: begin m_en = reg_wdata[0]; m_pol = reg_wdata[1]; end
          2'd1: m_pbuf = reg_wdata;
          2'd2: m_dbuf = reg_wdata;
          default: begin
            m_ie = reg_wdata[6]; m_force = reg_wdata[4];
            m_lvl = reg_wdata[1]; m_sden = reg_wdata[0];
          end
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                     input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison of the outputs against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk({7'b0, pwm_out}, {7'b0, model_out()}, cur_req, "pwm_out");
      chk({7'b0, irq}, {7'b0, (m_flag && m_ie)}, cur_req, "irq");
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = 2'(a);
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd_chk(input int a, input string req);
    @(negedge clk);
    reg_addr = 2'(a);
    #1;
    chk(reg_rdata, model_read(a), req, "readback");
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00; sd_pin = 1'b0;
    run(3);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin
      rd_chk(a, "R1");
      chk(reg_rdata, 8'h00, "R1", "reset word");
    end
    // R5: buffered readback
    cur_req = "R5";
    wr(1, 8'd5);
    wr(2, 8'd2);
    rd_chk(1, "R5");
    rd_chk(2, "R5");
    // R2: polarity 1
    cur_req = "R2";
    wr(0, 8'h03);
    run(20);
    // R3: polarity 0
    cur_req = "R3";
    wr(0, 8'h01);
    run(15);
    // R5: mid-period update takes effect at wrap
    cur_req = "R5";
    wr(2, 8'd4);
    rd_chk(2, "R5");
    run(12);
    wr(1, 8'd7);
    run(20);
    // R4: boundary duties
    cur_req = "R4";
    wr(2, 8'd0);
    run(16);
    wr(2, 8'd9);
    run(16);
    wr(0, 8'h03);
    run(16);
    wr(2, 8'd0);
    run(16);
    wr(1, 8'd0);
    run(8);
    wr(1, 8'd7);
    // R2: slow tick
    cur_req = "R2";
    wr(2, 8'd3);
    tick_div = 3;
    run(45);
    tick_div = 1;
    // R6: disabled channel
    cur_req = "R6";
    wr(0, 8'h02);
    wr(1, 8'd6);
    wr(2, 8'd2);
    run(6);
    chk({7'b0, pwm_out}, 8'h00, "R6", "disabled out");
    wr(0, 8'h03);
    run(14);
    // R11: shutdown word layout
    cur_req = "R11";
    wr(3, 8'h53);
    rd_chk(3, "R11");
    // R7: single-cycle pulse is filtered
    cur_req = "R7";
    @(negedge clk); sd_pin = 1'b1;
    @(negedge clk); sd_pin = 1'b0;
    run(5);
    rd_chk(3, "R7");
    chk(reg_rdata[7], 1'b0, "R7", "flag after glitch");
    // R8: sustained trip forces output
    cur_req = "R8";
    @(negedge clk); sd_pin = 1'b1;
    run(6);
    chk({7'b0, pwm_out}, 8'h01, "R8", "forced level");
    rd_chk(3, "R11");
    // R9: flag clear and irq
    cur_req = "R9";
    wr(3, 8'hD3);
    run(3);
    chk({7'b0, irq}, 8'h01, "R9", "irq while tripped");
    sd_pin = 1'b0;
    run(3);
    wr(3, 8'hD3);
    run(2);
    rd_chk(3, "R9");
    chk({7'b0, irq}, 8'h00, "R9", "irq after clear");
    // R10: restart armed while input active, released later at period start
    cur_req = "R10";
    sd_pin = 1'b1;
    run(3);
    wr(3, 8'h63);
    tick_div = 3;
    run(25);
    sd_pin = 1'b0;
    run(40);
    tick_div = 1;
    wr(3, 8'hD3);
    run(10);
    // R12: disabling shutdown releases at once
    cur_req = "R12";
    sd_pin = 1'b1;
    run(4);
    wr(3, 8'h52);
    run(5);
    sd_pin = 1'b0;
    run(4);
    // R8: active-low input, forced low, polarity 0
    cur_req = "R8";
    sd_pin = 1'b1;
    run(3);
    wr(0, 8'h01);
    wr(3, 8'h41);
    run(10);
    sd_pin = 1'b0;
    run(8);
    sd_pin = 1'b1;
    cur_req = "R10";
    wr(3, 8'h61);
    run(25);
    cur_req = "R9";
    wr(3, 8'hC1);
    rd_chk(3, "R9");
    run(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule